// File: doc/BRIEF.md
# Indirect Bus Command Bridge

This block lets a host reach a 32-bit internal request/response bus through a small window of 64-bit registers. The host first loads a 32-bit value into the data register. It then writes a command word that holds the target address, the access size and a read/write flag. That single command write launches one transaction on the internal bus. When the bus answers, or when a cycle budget runs out, the bridge writes the outcome into a status register. The host polls that register, and each read of it clears it.

Bytes move big-endian in both directions. The most significant byte of a 32-bit value always belongs to the lowest bus address. Read data comes back inside the status word at a fixed shifted position, next to a done flag. A read that fails still reports done, and its data field is all ones. Only one transaction can be in flight at a time. While it is pending, any further command is dropped.

Top module: `ind_bus_bridge`

## Requirements
- R1: The two-bit register select picks control (0), reset (1), status (2) or data (3). Every access carries a full 64-bit word. A read of any register returns its value on `reg_rdata` with `reg_rvalid` high exactly one cycle after the request. Reads of control or reset return zero.
- R2: A write to the data register stores bits 63:32 of the word. A read of the data register returns the stored value in bits 63:32 and zero in bits 31:0.
- R3: A control write decodes the command word as follows: bit 48 set means a read and clear means a write, bits 59:56 give the size, and bits 31:0 give the target address. These fields appear on `bus_we` (high for a write), `bus_size` and `bus_addr`.
- R4: A write command drives the data register onto `bus_wdata`. Bits 31:24 carry the byte for the lowest address. Once the write completes, status equals the done flag alone, bit 11 (0x800).
- R5: A successful read places `bus_rdata` into status bits 57:26 and sets the done flag at bit 11. Bits 31:24 of `bus_rdata` are the byte at the lowest address and land at status bits 57:50.
- R6: A read that ends with `bus_err` set still sets the done flag, but status bits 57:26 are all ones.
- R7: A status read returns the current value and leaves status at zero.
- R8: Writes to the status register or the reset register change neither status nor the data register.
- R9: While a transaction is outstanding, control writes are ignored and status reads zero until the result is captured.
- R10: `bus_req` and the address, size, direction and write data stay constant until `bus_ack`. `bus_req` falls in the cycle after the acknowledge.
- R11: If no acknowledge arrives, `bus_req` stays high for exactly TIMEOUT cycles. The transaction then ends as a bus error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 64 | Register write word |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 64 | Read data word |
| bus_req | output | 1 | Internal bus request |
| bus_we | output | 1 | Internal bus write enable |
| bus_addr | output | 32 | Internal bus address |
| bus_size | output | 4 | Internal bus access size |
| bus_wdata | output | 32 | Internal bus write data |
| bus_ack | input | 1 | Internal bus acknowledge |
| bus_err | input | 1 | Error flag qualifying the acknowledge |
| bus_rdata | input | 32 | Internal bus read data |

## Verification
A stuck busy state shows up on the first extra command: the bus never sees its request, and the next status read stays zero long past the expected latency. A wrong captured-direction bit shows up as a status word with the wrong shape, either done alone or done with data, on the very first poll after completion. A timer that is off by one changes the measured width of `bus_req` on a silent target by exactly one cycle. Byte-order or shift errors change the read word at the next status poll.

// File: rtl/ind_bus_bridge_pkg.sv
package ind_bus_bridge_pkg;

    localparam logic [1:0] SEL_CTL  = 2'd0;
    localparam logic [1:0] SEL_RST  = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;
    localparam logic [1:0] SEL_DATA = 2'd3;

    localparam int DONE_BIT  = 11;
    localparam int RD_LSB    = 26;
    localparam int DIR_BIT   = 48;
    localparam int SIZE_LSB  = 56;

    typedef struct packed {
        logic        is_read;
        logic [3:0]  size;
        logic [31:0] addr;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [63:0] w);
        cmd_t c;
        c.is_read = w[DIR_BIT];
        c.size    = w[SIZE_LSB +: 4];
        c.addr    = w[31:0];
        return c;
    endfunction

    function automatic logic [63:0] pack_status(input logic [31:0] rd);
        logic [63:0] s;
        s = '0;
        s[DONE_BIT] = 1'b1;
        s[RD_LSB +: 32] = rd;
        return s;
    endfunction

endpackage

// File: rtl/ind_bus_bridge_master.sv
module ind_bus_bridge_master
    import ind_bus_bridge_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  cmd_t        cmd,
    input  logic [31:0] wdata,
    output logic        busy,
    output logic        done,
    output logic        done_rd,
    output logic        done_err,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [3:0]  bus_size,
    output logic [31:0] bus_wdata,
    input  logic        bus_ack,
    input  logic        bus_err
);

    localparam int TMR_W = $clog2(TIMEOUT + 1);

    typedef enum logic {ST_IDLE, ST_WAIT} st_e;

    typedef struct packed {
        st_e              st;
        logic [TMR_W-1:0] tmr;
        logic             we;
        logic [31:0]      addr;
        logic [3:0]       size;
        logic [31:0]      wdata;
    } mst_t;

    mst_t q, d;
    logic tmo_hit;

    assign tmo_hit = (q.st == ST_WAIT) && (q.tmr == TMR_W'(TIMEOUT - 1));

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st    = ST_WAIT;
                    d.tmr   = '0;
                    d.we    = ~cmd.is_read;
                    d.addr  = cmd.addr;
                    d.size  = cmd.size;
                    d.wdata = wdata;
                end
            end
            default: begin
                if (bus_ack || tmo_hit) d.st = ST_IDLE;
                else                    d.tmr = q.tmr + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign busy      = (q.st == ST_WAIT);
    assign done      = busy && (bus_ack || tmo_hit);
    assign done_rd   = ~q.we;
    assign done_err  = bus_ack ? bus_err : 1'b1;
    assign bus_req   = busy;
    assign bus_we    = q.we;
    assign bus_addr  = q.addr;
    assign bus_size  = q.size;
    assign bus_wdata = q.wdata;

    // R10: request and its fields hold until the transaction ends
    p_hold_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && !tmo_hit |=> bus_req && $stable(bus_addr)
            && $stable(bus_we) && $stable(bus_size) && $stable(bus_wdata));

    // R10: request drops right after acknowledge
    p_req_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack |=> !bus_req);

    // R11: the wait timer never passes the budget
    p_tmo_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> q.tmr < TMR_W'(TIMEOUT));

endmodule

// File: rtl/ind_bus_bridge_regs.sv
module ind_bus_bridge_regs
    import ind_bus_bridge_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_valid,
    input  logic        reg_write,
    input  logic [1:0]  reg_sel,
    input  logic [63:0] reg_wdata,
    output logic        reg_rvalid,
    output logic [63:0] reg_rdata,
    input  logic        busy,
    input  logic        done,
    input  logic        done_rd,
    input  logic        done_err,
    input  logic [31:0] bus_rdata,
    output logic        start,
    output cmd_t        cmd,
    output logic [31:0] wdata
);

    typedef struct packed {
        logic [31:0] data;
        logic [63:0] status;
        logic [63:0] rdata;
        logic        rvalid;
    } rf_t;

    rf_t q, d;

    assign start = reg_valid && reg_write && (reg_sel == SEL_CTL) && !busy;
    assign cmd   = decode_cmd(reg_wdata);
    assign wdata = q.data;

    always_comb begin
        d = q;
        d.rvalid = 1'b0;
        if (reg_valid && !reg_write) begin
            d.rvalid = 1'b1;
            case (reg_sel)
                SEL_STAT: begin
                    d.rdata  = q.status;
                    d.status = '0;
                end
                SEL_DATA: d.rdata = {q.data, 32'h0};
                default:  d.rdata = '0;
            endcase
        end
        if (reg_valid && reg_write && reg_sel == SEL_DATA)
            d.data = reg_wdata[63:32];
        if (start)
            d.status = '0;
        if (done) begin
            if (!done_rd)      d.status = 64'(1) << DONE_BIT;
            else if (done_err) d.status = pack_status(32'hFFFF_FFFF);
            else               d.status = pack_status(bus_rdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign reg_rvalid = q.rvalid;
    assign reg_rdata  = q.rdata;

    // R1: every read request gets a response the next cycle
    p_read_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && !reg_write |=> reg_rvalid);

    // R9: status stays empty while the bus is busy
    p_busy_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> q.status == 64'h0);

    // R4: a completed transaction always leaves the done flag set
    p_done_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> q.status[DONE_BIT]);

    // R2: data register reads carry zeros in the low word
    p_data_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && !reg_write && reg_sel == SEL_DATA |=> reg_rdata[31:0] == 32'h0);

endmodule

// File: rtl/ind_bus_bridge.sv
module ind_bus_bridge
    import ind_bus_bridge_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_valid,
    input  logic        reg_write,
    input  logic [1:0]  reg_sel,
    input  logic [63:0] reg_wdata,
    output logic        reg_rvalid,
    output logic [63:0] reg_rdata,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [3:0]  bus_size,
    output logic [31:0] bus_wdata,
    input  logic        bus_ack,
    input  logic        bus_err,
    input  logic [31:0] bus_rdata
);

    logic        start, busy, done, done_rd, done_err;
    cmd_t        cmd;
    logic [31:0] wdata;

    ind_bus_bridge_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
        .busy(busy), .done(done), .done_rd(done_rd), .done_err(done_err),
        .bus_rdata(bus_rdata), .start(start), .cmd(cmd), .wdata(wdata)
    );

    ind_bus_bridge_master #(.TIMEOUT(TIMEOUT)) u_master (
        .clk(clk), .rst_n(rst_n),
        .start(start), .cmd(cmd), .wdata(wdata),
        .busy(busy), .done(done), .done_rd(done_rd), .done_err(done_err),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err)
    );

endmodule

// File: tb/ind_bus_bridge_bench.sv
`timescale 1ns/1ps
module ind_bus_bridge_bench;

    localparam int TMO = 20;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [63:0] reg_wdata = '0;
    logic        reg_rvalid;
    logic [63:0] reg_rdata;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_size;
    logic        bus_ack = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #2 clk = ~clk;

    ind_bus_bridge #(.TIMEOUT(TMO)) u_ind_bus_bridge (.*);

    int nvec = 0, nbad = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] slave_word(input logic [31:0] a);
        return a ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [63:0] rd_ok(input logic [31:0] v);
        return (64'(v) << 26) | 64'h800;
    endfunction

    function automatic logic [63:0] mkcmd(input logic rd, input logic [3:0] sz, input logic [31:0] a);
        return (64'(sz) << 56) | (64'(rd) << 48) | 64'(a);
    endfunction

    // bus slave model: top nibble D = silent, E = error
    int          txn_cnt = 0, wait_cnt = 0, req_hi = 0;
    logic        req_prev = 1'b0;
    logic        l_we;
    logic [31:0] l_addr, l_wdata;
    logic [3:0]  l_size;

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_ack) begin
                bus_ack = 1'b0;
                check("R10 req drop after ack", 64'(bus_req), 64'd0);
            end else if (bus_req) begin
                if (!req_prev) begin
                    txn_cnt++; wait_cnt = 0; req_hi = 0;
                end
                req_hi++; wait_cnt++;
                if (bus_addr[31:28] != 4'hD && wait_cnt == LAT) begin
                    bus_ack   = 1'b1;
                    bus_err   = (bus_addr[31:28] == 4'hE);
                    bus_rdata = slave_word(bus_addr);
                    l_we = bus_we; l_addr = bus_addr; l_size = bus_size; l_wdata = bus_wdata;
                end
            end
            req_prev = bus_req;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            if (exp_q.size() == 0) begin
                nvec++; nbad++;
                $display("FAIL R1 unexpected read response actual=%h expected=none", reg_rdata);
            end else begin
                check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic reg_wr(input logic [1:0] s, input logic [63:0] w);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_sel = s; reg_wdata = w;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] s, input logic [63:0] e, input string tag);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_sel = s;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        reg_valid = 1'b0;
    endtask

    task automatic finish_run;
        repeat (3) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nvec++; nbad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R10 reset no request", 64'(bus_req), 64'd0);
        reg_rd(2'd2, 64'h0, "R7 reset status");
        reg_rd(2'd3, 64'h0, "R2 reset data");

        reg_wr(2'd3, 64'hDEAD_BEEF_0000_FFFF);
        reg_rd(2'd3, 64'hDEAD_BEEF_0000_0000, "R2 data readback");
        reg_rd(2'd0, 64'h0, "R1 control reads zero");
        reg_rd(2'd1, 64'h0, "R1 reset reads zero");

        // read command
        reg_wr(2'd0, mkcmd(1'b1, 4'd4, 32'h0000_1234));
        repeat (LAT + 4) @(negedge clk);
        check("R3 read direction", 64'(l_we), 64'd0);
        check("R3 address", 64'(l_addr), 64'h1234);
        check("R3 size", 64'(l_size), 64'd4);
        reg_rd(2'd2, rd_ok(slave_word(32'h1234)), "R5 read status");
        reg_rd(2'd2, 64'h0, "R7 status cleared");

        // write command
        reg_wr(2'd3, 64'h1122_3344_0000_0000);
        reg_wr(2'd0, mkcmd(1'b0, 4'd2, 32'h0000_2000));
        repeat (LAT + 4) @(negedge clk);
        check("R3 write direction", 64'(l_we), 64'd1);
        check("R3 size write", 64'(l_size), 64'd2);
        check("R4 write data byte order", 64'(l_wdata), 64'h1122_3344);
        reg_rd(2'd2, 64'h800, "R4 write status");

        // error read
        reg_wr(2'd0, mkcmd(1'b1, 4'd4, 32'hE000_0010));
        repeat (LAT + 4) @(negedge clk);
        reg_rd(2'd2, rd_ok(32'hFFFF_FFFF), "R6 error status");

        // ignored writes
        reg_wr(2'd0, mkcmd(1'b1, 4'd1, 32'h0000_5678));
        repeat (LAT + 4) @(negedge clk);
        reg_wr(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_rd(2'd2, rd_ok(slave_word(32'h5678)), "R8 status unchanged");
        reg_rd(2'd3, 64'h1122_3344_0000_0000, "R8 data unchanged");

        // busy: second command dropped
        base = txn_cnt;
        reg_wr(2'd0, mkcmd(1'b1, 4'd4, 32'h0000_00A0));
        reg_wr(2'd0, mkcmd(1'b0, 4'd4, 32'h0000_00B0));
        reg_rd(2'd2, 64'h0, "R9 status zero while busy");
        repeat (LAT + 6) @(negedge clk);
        check("R9 one transaction only", 64'(txn_cnt - base), 64'd1);
        check("R9 first address kept", 64'(l_addr), 64'hA0);
        reg_rd(2'd2, rd_ok(slave_word(32'h00A0)), "R9 first result");

        // timeout
        reg_wr(2'd0, mkcmd(1'b1, 4'd4, 32'hD000_0000));
        repeat (TMO + 6) @(negedge clk);
        check("R11 request width", 64'(req_hi), 64'(TMO));
        reg_rd(2'd2, rd_ok(32'hFFFF_FFFF), "R11 timeout status");

        repeat (3) @(negedge clk);
        check("R1 all reads answered", 64'(exp_q.size()), 64'd0);
        finish_run();
    end

endmodule